// File: doc/BRIEF.md
# Burst SPI Master with Programmable Clock and Partial Final Byte

This block is a full-duplex SPI master that moves a burst of 1 to 50 bytes in one go. A single start strobe latches the transfer settings: the SPI mode, whether chip select is driven by the block, an 8-bit clock factor, and how many bits of the last byte are shifted. Transmit bytes are fetched one at a time through a request strobe and an index, with the data returned in the same cycle. Each received byte is reported with a valid strobe and its index. When the burst is over, a one-cycle done pulse carries the number of bytes moved.

The serial clock comes from a timebase enable, nominally at a 1 MHz rate, divided down from the system clock. One SCK period lasts `10 * (257 - F)` ticks, where F is the clock factor and a factor of 0 counts as 256. SCK is moved to its idle level before chip select falls. It is back at that level before chip select rises. A count of 0 or above 50 is refused with an error pulse and causes no pin activity.

The controller is a seven-state machine:
- `ST_IDLE` leaves on a valid start and goes to `ST_PARK`, which puts SCK at its idle level.
- `ST_PARK` moves to `ST_LOAD`, which asserts chip select and fetches a transmit byte.
- `ST_LOAD` moves to `ST_HALF_A`, which holds SCK idle for the first half-period. When that half ends, the leading edge takes it to `ST_HALF_B`.
- `ST_HALF_B` ends on the trailing edge. From there it goes back to `ST_HALF_A` for the next bit, back to `ST_LOAD` for the next byte, or on to `ST_TAIL` after the last bit.
- `ST_TAIL` waits one half-period and goes to `ST_FINISH`.
- `ST_FINISH` releases chip select, pulses done and returns to `ST_IDLE`.

Top module: `spi_burst_master`

## Requirements
- R1: The 2-bit mode sets SCK polarity and phase: 0 is idle-low with phase 0, 1 is idle-low with phase 1, 2 is idle-high with phase 0, and 3 is idle-high with phase 1. SCK is at the idle level whenever chip select falls or rises, and between bursts.
- R2: With phase 0, MISO is sampled on the SCK edge that leaves the idle level, and MOSI changes on the edge that returns to it. With phase 1, MOSI changes on the edge leaving idle, and MISO is sampled on the edge returning to idle.
- R3: With auto chip select on, `cs_n` is low for the whole burst, every SCK edge falls inside that window, and `cs_n` returns high at the end. With auto chip select off, `cs_n` stays high.
- R4: Within a byte, one SCK period lasts `10*(257-F)` timebase ticks, where F is the clock factor and F=0 counts as 256. So F=0 gives 10 ticks and F=255 gives 20.
- R5: A burst moves exactly the requested 1 to 50 bytes. There is one transmit request (`tx_req`, with index `tx_idx`) and one `rx_valid` (with index `rx_idx`) per byte, with indices counting up from 0.
- R6: The 3-bit last-bit field gives the number of bits shifted in the final byte, and 0 means 8. The final byte sends the top bits of its transmit byte. The bits received during them sit in the top bits of the final received byte, and its unused low bits read 0.
- R7: Bits go out and come in most significant bit first.
- R8: A start with a count of 0 or more than 50 gives a one-cycle `err` pulse one cycle later. It starts no burst: SCK does not toggle, `cs_n` stays high and `done` stays low.
- R9: The two halves of an SCK period are equal, at `5*(257-F)` ticks each. If the period were odd, the first half would take the extra tick.
- R10: `start` is ignored while a burst is running. `done` is a one-cycle pulse, and `bytes_done` equals the requested count while it is high.
- R11: After reset, `cs_n` is 1, SCK is 0, and `done`, `err`, `rx_valid` and `tx_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (taken only when idle) |
| xfer_bytes | input | CNT_W | Number of bytes in the burst (1..MAX_BYTES) |
| spi_mode | input | 2 | Polarity/phase select (see R1) |
| auto_cs | input | 1 | Drive chip select automatically |
| clk_factor | input | 8 | SCK rate factor F |
| last_bits | input | 3 | Bits in the final byte, 0 means 8 |
| tx_req | output | 1 | Transmit byte is sampled this cycle |
| tx_idx | output | CNT_W | Index of the requested transmit byte |
| tx_data | input | 8 | Transmit byte, valid while tx_req is high |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| rx_valid | output | 1 | Received byte strobe |
| rx_idx | output | CNT_W | Index of the received byte |
| rx_data | output | 8 | Received byte, MSB aligned |
| done | output | 1 | One-cycle end-of-burst pulse |
| bytes_done | output | CNT_W | Bytes moved, valid with done |
| err | output | 1 | One-cycle pulse on a refused start |

## Verification
The bench builds the block with `TICK_DIV=1`, so every system cycle is one timebase tick. That makes the measured SCK period and half-period in cycles equal the tick counts of R4 and R9. With this setting even the slowest factor (F=1, 2560 ticks) fits in a short run, along with a full 50-byte burst. It keeps `MAX_BYTES=50` and `CNT_W=8`, so both refused counts, 0 and 51, can be driven on the count port.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PARK,
        ST_LOAD,
        ST_HALF_A,
        ST_HALF_B,
        ST_TAIL,
        ST_FINISH
    } burst_state_e;

    localparam int PER_W = 12;

    // SCK period in timebase ticks: 10*(257-F), F=0 meaning 256
    function automatic logic [PER_W-1:0] sck_period_ticks(input logic [7:0] factor);
        int unsigned f_eff;
        f_eff = (factor == 8'd0) ? 256 : int'(factor);
        return PER_W'(10 * (257 - f_eff));
    endfunction

endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every_cycle
            assign tick = !restart;
        end else begin : g_divider
            localparam int DW = $clog2(TICK_DIV);
            logic [DW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (restart || cnt == DW'(TICK_DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = !restart && (cnt == DW'(TICK_DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] target,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = !clear && tick && (cnt == target - W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       cpha,
    input  logic       lead_edge,
    input  logic       trail_edge,
    input  logic       miso,
    output logic       mosi,
    output logic [7:0] rx_now
);
    logic [7:0] tx_sr;
    logic [7:0] rx_sr;

    // phase 1 samples on the trailing edge, in the same cycle the byte closes
    assign rx_now = cpha ? {rx_sr[6:0], miso} : rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            mosi  <= 1'b0;
        end else if (load) begin
            tx_sr <= din;
            rx_sr <= '0;
            if (!cpha) begin
                mosi <= din[7];
            end
        end else if (lead_edge) begin
            if (!cpha) begin
                rx_sr <= {rx_sr[6:0], miso};
            end else begin
                mosi  <= tx_sr[7];
                tx_sr <= {tx_sr[6:0], 1'b0};
            end
        end else if (trail_edge) begin
            if (!cpha) begin
                mosi  <= tx_sr[6];
                tx_sr <= {tx_sr[6:0], 1'b0};
            end else begin
                rx_sr <= {rx_sr[6:0], miso};
            end
        end
    end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int TICK_DIV  = 50,
    parameter int MAX_BYTES = 50,
    parameter int CNT_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] xfer_bytes,
    input  logic [1:0]       spi_mode,
    input  logic             auto_cs,
    input  logic [7:0]       clk_factor,
    input  logic [2:0]       last_bits,
    output logic             tx_req,
    output logic [CNT_W-1:0] tx_idx,
    input  logic [7:0]       tx_data,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n,
    output logic             rx_valid,
    output logic [CNT_W-1:0] rx_idx,
    output logic [7:0]       rx_data,
    output logic             done,
    output logic [CNT_W-1:0] bytes_done,
    output logic             err
);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

    burst_state_e state_q, state_d;

    logic [1:0]       mode_q;
    logic             cpol_q;
    logic             auto_q;
    logic [CNT_W-1:0] nbytes_q;
    logic [2:0]       lb_q;
    logic [PER_W-1:0] period_q;
    logic [CNT_W-1:0] byte_q;
    logic [3:0]       bit_q;
    logic [CNT_W-1:0] moved_q;
    logic             sck_q;
    logic             err_q;
    logic             rxv_q;
    logic [CNT_W-1:0] rxi_q;
    logic [7:0]       rxd_q;

    logic             count_ok;
    logic             tick;
    logic             hit;
    logic             timed;
    logic [PER_W-1:0] half_a;
    logic [PER_W-1:0] half_b;
    logic [PER_W-1:0] target;
    logic             lead_edge;
    logic             trail_edge;
    logic             last_byte;
    logic [3:0]       bits_now;
    logic             byte_end;
    logic [7:0]       rx_now;
    logic [7:0]       rx_aligned;

    assign count_ok  = (xfer_bytes != '0) && (xfer_bytes <= MAX_CNT);
    assign cpol_q    = mode_q[1];
    assign last_byte = (byte_q == nbytes_q - CNT_W'(1));
    assign bits_now  = (last_byte && lb_q != 3'd0) ? {1'b0, lb_q} : 4'd8;
    assign byte_end  = (bit_q == bits_now - 4'd1);
    assign half_a    = (period_q + PER_W'(1)) >> 1;
    assign half_b    = period_q >> 1;
    assign timed     = (state_q == ST_HALF_A) || (state_q == ST_HALF_B) || (state_q == ST_TAIL);
    assign target    = (state_q == ST_HALF_B) ? half_b : half_a;
    assign lead_edge  = (state_q == ST_HALF_A) && hit;
    assign trail_edge = (state_q == ST_HALF_B) && hit;
    assign rx_aligned = rx_now << (4'd8 - bits_now);

    spi_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == ST_IDLE),
        .tick    (tick)
    );

    spi_half_timer #(.W(PER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!timed),
        .tick   (tick),
        .target (target),
        .hit    (hit)
    );

    spi_bit_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state_q == ST_LOAD),
        .din        (tx_data),
        .cpha       (mode_q[0]),
        .lead_edge  (lead_edge),
        .trail_edge (trail_edge),
        .miso       (miso),
        .mosi       (mosi),
        .rx_now     (rx_now)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start && count_ok) state_d = ST_PARK;
            ST_PARK:   state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_HALF_A;
            ST_HALF_A: if (hit) state_d = ST_HALF_B;
            ST_HALF_B: begin
                if (hit) begin
                    if (!byte_end)      state_d = ST_HALF_A;
                    else if (last_byte) state_d = ST_TAIL;
                    else                state_d = ST_LOAD;
                end
            end
            ST_TAIL:   if (hit) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 2'd0;
            auto_q   <= 1'b0;
            nbytes_q <= '0;
            lb_q     <= 3'd0;
            period_q <= PER_W'(10);
            byte_q   <= '0;
            bit_q    <= 4'd0;
            moved_q  <= '0;
            sck_q    <= 1'b0;
            err_q    <= 1'b0;
            rxv_q    <= 1'b0;
            rxi_q    <= '0;
            rxd_q    <= 8'd0;
        end else begin
            err_q <= 1'b0;
            rxv_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (count_ok) begin
                            mode_q   <= spi_mode;
                            auto_q   <= auto_cs;
                            nbytes_q <= xfer_bytes;
                            lb_q     <= last_bits;
                            period_q <= sck_period_ticks(clk_factor);
                            byte_q   <= '0;
                            moved_q  <= '0;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_PARK: sck_q <= cpol_q;
                ST_LOAD: bit_q <= 4'd0;
                ST_HALF_A: if (hit) sck_q <= ~sck_q;
                ST_HALF_B: begin
                    if (hit) begin
                        sck_q <= ~sck_q;
                        bit_q <= bit_q + 4'd1;
                        if (byte_end) begin
                            rxv_q   <= 1'b1;
                            rxi_q   <= byte_q;
                            rxd_q   <= rx_aligned;
                            moved_q <= moved_q + CNT_W'(1);
                            if (!last_byte) begin
                                byte_q <= byte_q + CNT_W'(1);
                            end
                        end
                    end
                end
                ST_TAIL:   ;
                ST_FINISH: ;
                default:   ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cs_n       = 1'b1;
        tx_req     = (state_q == ST_LOAD);
        tx_idx     = byte_q;
        done       = (state_q == ST_FINISH);
        bytes_done = moved_q;
        unique case (state_q)
            ST_LOAD, ST_HALF_A, ST_HALF_B, ST_TAIL: cs_n = !auto_q;
            default: cs_n = 1'b1;
        endcase
    end

    assign sck      = sck_q;
    assign err      = err_q;
    assign rx_valid = rxv_q;
    assign rx_idx   = rxi_q;
    assign rx_data  = rxd_q;

endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
    parameter int MAX_BYTES = 50,
    parameter int CNT_W     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             sck,
    input logic             cpol,
    input logic             auto_on,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] bytes_done,
    input logic [CNT_W-1:0] nbytes,
    input logic [2:0]       lastb,
    input logic             err,
    input logic             rx_valid,
    input logic [CNT_W-1:0] rx_idx,
    input logic [7:0]       rx_data
);
    p_cs_fall_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> sck == cpol);

    p_cs_rise_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> sck == cpol);

    p_manual_cs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_on |-> cs_n);

    p_rx_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_idx < CNT_W'(MAX_BYTES));

    p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_idx == nbytes - CNT_W'(1) && lastb != 3'd0)
            |-> (rx_data & (8'hFF >> lastb)) == 8'd0);

    p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !busy && !done));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bytes_done == nbytes);
endmodule

bind spi_burst_master spi_burst_master_chk #(
    .MAX_BYTES (MAX_BYTES),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .cpol       (cpol_q),
    .auto_on    (auto_q),
    .busy       (state_q != spi_burst_pkg::ST_IDLE),
    .done       (done),
    .bytes_done (bytes_done),
    .nbytes     (nbytes_q),
    .lastb      (lb_q),
    .err        (err),
    .rx_valid   (rx_valid),
    .rx_idx     (rx_idx),
    .rx_data    (rx_data)
);

// File: tb/tb_spi_burst_master.sv
module tb_spi_burst_master;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] xfer_bytes = '0;
    logic [1:0]       spi_mode = 2'd0;
    logic             auto_cs = 1'b1;
    logic [7:0]       clk_factor = 8'd0;
    logic [2:0]       last_bits = 3'd0;
    logic             tx_req;
    logic [CNT_W-1:0] tx_idx;
    logic [7:0]       tx_data;
    logic             sck, mosi, cs_n;
    logic             miso = 1'b0;
    logic             rx_valid;
    logic [CNT_W-1:0] rx_idx;
    logic [7:0]       rx_data;
    logic             done;
    logic [CNT_W-1:0] bytes_done;
    logic             err;

    always #10 clk = ~clk;

    spi_burst_master #(.TICK_DIV(1), .MAX_BYTES(50), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_bytes(xfer_bytes),
        .spi_mode(spi_mode), .auto_cs(auto_cs), .clk_factor(clk_factor),
        .last_bits(last_bits), .tx_req(tx_req), .tx_idx(tx_idx), .tx_data(tx_data),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_idx(rx_idx), .rx_data(rx_data), .done(done), .bytes_done(bytes_done),
        .err(err)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        acs;
        logic [7:0]  fac;
        logic [7:0]  nb;
        logic [2:0]  lb;
        logic [11:0] per;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b1, 8'd0,   8'd1,  3'd0, 12'd10},
        '{2'd1, 1'b1, 8'd255, 8'd2,  3'd3, 12'd20},
        '{2'd2, 1'b1, 8'd250, 8'd3,  3'd0, 12'd70},
        '{2'd3, 1'b1, 8'd0,   8'd4,  3'd7, 12'd10},
        '{2'd0, 1'b0, 8'd0,   8'd2,  3'd1, 12'd10},
        '{2'd3, 1'b1, 8'd200, 8'd1,  3'd2, 12'd570},
        '{2'd1, 1'b1, 8'd0,   8'd50, 3'd0, 12'd10},
        '{2'd2, 1'b1, 8'd1,   8'd1,  3'd2, 12'd2560}
    };

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [7:0] txmem [64];
    logic [7:0] stx   [64];
    logic [7:0] srx   [64];
    logic [7:0] drx   [64];

    assign tx_data = txmem[tx_idx[5:0]];

    // slave model state
    logic cur_cpol = 1'b0, cur_cpha = 1'b0, cur_acs = 1'b1;
    logic prev_sck = 1'b0, prev_cs = 1'b1;
    logic pending  = 1'b0;
    int   kbit = 0;
    int   lead_cnt = 0, trail_cnt = 0;
    int   lead0 = 0, lead1 = 0, trail0 = 0;
    int   sck_changes = 0, cs_falls = 0, cs_rises = 0, cs_low_cyc = 0;
    int   outside_cs = 0, bad_park = 0;
    int   rx_seen = 0, txreq_seen = 0, done_seen = 0;

    function automatic logic sbit(input int k);
        if (k >= 64 * 8) return 1'b0;
        return stx[k / 8][7 - (k % 8)];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (sck != prev_sck) begin
            sck_changes++;
            if (cur_acs && cs_n) outside_cs++;
            if (sck != cur_cpol) begin
                // edge leaving idle
                if (lead_cnt == 0) lead0 = cyc;
                if (lead_cnt == 1) lead1 = cyc;
                lead_cnt++;
                if (!cur_cpha) srx[kbit / 8][7 - (kbit % 8)] = mosi;
                else           miso = sbit(kbit);
                pending = 1'b1;
            end else if (pending) begin
                if (trail_cnt == 0) trail0 = cyc;
                trail_cnt++;
                if (!cur_cpha) begin
                    kbit++;
                    miso = sbit(kbit);
                end else begin
                    srx[kbit / 8][7 - (kbit % 8)] = mosi;
                    kbit++;
                end
                pending = 1'b0;
            end
        end
        if (cs_n != prev_cs) begin
            if (!cs_n) cs_falls++; else cs_rises++;
            if (sck != cur_cpol) bad_park++;
        end
        if (!cs_n) cs_low_cyc++;
        if (rx_valid) begin
            drx[rx_idx[5:0]] = rx_data;
            rx_seen++;
        end
        if (tx_req) txreq_seen++;
        if (done) done_seen++;
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        while (cyc < 150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    task automatic clear_monitor(input vec_t v, input int seed);
        cur_cpol = v.mode[1];
        cur_cpha = v.mode[0];
        cur_acs  = v.acs;
        for (int i = 0; i < 64; i++) begin
            txmem[i] = 8'(i * 37 + seed * 11 + 8'h5A);
            stx[i]   = 8'(8'hC3 ^ (i * 23 + seed * 7));
            srx[i]   = 8'h00;
            drx[i]   = 8'h00;
        end
        kbit = 0; pending = 1'b0;
        lead_cnt = 0; trail_cnt = 0; lead0 = 0; lead1 = 0; trail0 = 0;
        sck_changes = 0; cs_falls = 0; cs_rises = 0; cs_low_cyc = 0;
        outside_cs = 0; bad_park = 0;
        rx_seen = 0; txreq_seen = 0; done_seen = 0;
        miso = cur_cpha ? 1'b0 : sbit(0);
    endtask

    task automatic launch(input vec_t v);
        @(negedge clk);
        spi_mode   = v.mode;
        auto_cs    = v.acs;
        clk_factor = v.fac;
        xfer_bytes = v.nb;
        last_bits  = v.lb;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
    endtask

    task automatic wait_done(output int cnt);
        while (!done) @(negedge clk);
        cnt = int'(bytes_done);
        @(negedge clk);
        check(!done, "R10 done one cycle", int'(done), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input int vi);
        vec_t v;
        int cnt, nbits, total;
        logic [7:0] mask, exp_s, exp_d;
        v = VECS[vi];
        clear_monitor(v, vi);
        launch(v);
        wait_done(cnt);
        nbits = (v.lb == 3'd0) ? 8 : int'(v.lb);
        total = 8 * (int'(v.nb) - 1) + nbits;
        check(cnt == int'(v.nb), "R10 bytes_done", cnt, int'(v.nb));
        check(done_seen == 1, "R10 single done", done_seen, 1);
        check(rx_seen == int'(v.nb), "R5 rx strobes", rx_seen, int'(v.nb));
        check(txreq_seen == int'(v.nb), "R5 tx requests", txreq_seen, int'(v.nb));
        check(trail_cnt == total, "R6 bit count", trail_cnt, total);
        for (int i = 0; i < int'(v.nb); i++) begin
            mask  = (i == int'(v.nb) - 1) ? 8'(8'hFF << (8 - nbits)) : 8'hFF;
            exp_s = txmem[i] & mask;
            exp_d = stx[i] & mask;
            check(srx[i] == exp_s, "R2 R7 R6 mosi byte", int'(srx[i]), int'(exp_s));
            check(drx[i] == exp_d, "R2 R7 R6 miso byte", int'(drx[i]), int'(exp_d));
        end
        check(bad_park == 0, "R1 sck parked at cs edge", bad_park, 0);
        check(sck == cur_cpol, "R1 sck idle after burst", int'(sck), int'(cur_cpol));
        if (v.acs) begin
            check(cs_falls == 1 && cs_rises == 1, "R3 cs one window", cs_falls * 10 + cs_rises, 11);
            check(outside_cs == 0, "R3 edges inside cs", outside_cs, 0);
        end else begin
            check(cs_low_cyc == 0, "R3 manual cs stays high", cs_low_cyc, 0);
        end
        if (nbits >= 2 || v.nb > 1) begin
            check(lead1 - lead0 == int'(v.per), "R4 sck period", lead1 - lead0, int'(v.per));
            check(trail0 - lead0 == int'(v.per) / 2, "R9 half period", trail0 - lead0, int'(v.per) / 2);
        end
    endtask

    task automatic bad_count(input logic [7:0] n);
        vec_t v;
        v = '{2'd2, 1'b1, 8'd0, n, 3'd0, 12'd10};
        clear_monitor(v, 9);
        @(negedge clk);
        spi_mode = v.mode; auto_cs = 1'b1; xfer_bytes = n; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, "R8 err pulse", int'(err), 1);
        @(negedge clk);
        check(err == 1'b0, "R8 err one cycle", int'(err), 0);
        repeat (40) @(negedge clk);
        check(sck_changes == 0 && cs_low_cyc == 0 && done_seen == 0,
              "R8 no activity", sck_changes + cs_low_cyc + done_seen, 0);
    endtask

    initial begin : main
        int cnt;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && sck == 1'b0, "R11 pins after reset", {cs_n, sck}, 2);
        check(!done && !err && !rx_valid && !tx_req, "R11 strobes after reset",
              {done, err, rx_valid, tx_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int vi = 0; vi < NV; vi++) begin
            run_vec(vi);
        end

        bad_count(8'd0);
        bad_count(8'd51);

        // start while busy is ignored
        clear_monitor(VECS[2], 3);
        launch('{2'd0, 1'b1, 8'd0, 8'd3, 3'd0, 12'd10});
        repeat (20) @(negedge clk);
        xfer_bytes = 8'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(cnt);
        check(cnt == 3, "R10 busy start ignored", cnt, 3);
        repeat (100) @(negedge clk);
        check(done_seen == 1 && cs_n == 1'b1, "R10 no second burst", done_seen, 1);

        finish_run();
    end
endmodule